// File: doc/BRIEF.md
# Receive Frame Queue with Per-Frame Status

This block sits behind the bit-level receiver of a serial port. Each time a frame finishes, the receiver hands it over with one pulse: the data byte, an optional ninth bit, a framing-fault flag and a parity-fault flag. The block keeps these frames in a two-slot ring. It also keeps one more frame in a holding stage that stands in for the receive shift register. The host sees the oldest frame at the head of the ring, together with its own status bits, and removes it with a pop strobe.

Status travels with the data. The host therefore reads a frame's status before it pops that frame. Once a frame is popped, its status is no longer visible. The holding stage can keep a finished frame while both slots are in use. An overrun is only declared when the next start bit arrives while that held frame is still waiting. The overrun mark is attached to the next frame that enters the ring. Dropping the enable empties everything and clears any pending overrun.

Top module: `rx_status_fifo`

## Requirements
- R1: During reset, and in the cycle after reset is released, `avail` is 0.
- R2: A frame that arrives on `frame_done` while the holding stage is empty and fewer than two frames are stored is written into the ring on that clock edge. If the ring was empty, it appears at the head after that edge with its data, ninth bit, framing flag and parity flag unchanged.
- R3: The ring holds at most two frames and returns them in arrival order. A frame that arrives after the head does not change the head.
- R4: `rd_pop` while `avail` is 1 removes the head frame at that clock edge. The next stored frame, if there is one, is at the head after that edge. Each frame is delivered once.
- R5: A frame that arrives while two frames are stored is kept in the holding stage and is not lost. On the first clock edge at which fewer than two frames are stored, it moves to the tail of the ring.
- R6: An overrun occurs when `start_det` is high on an edge at which a frame is held and two frames are stored. The held frame is then discarded. The next frame written into the ring carries `head_ovr` = 1, and no later frame carries the mark.
- R7: `start_det` with an empty holding stage does not cause an overrun. The later frames carry `head_ovr` = 0.
- R8: `rd_pop` while `avail` is 0 has no effect. A later frame is still delivered normally.
- R9: While `rx_en` is 0, the ring and the holding stage are emptied and a pending overrun is cleared. `start_det` and `frame_done` are ignored.
- R10: The status outputs always belong to the frame shown on `head_data`. They change only when the head frame changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; low flushes all state |
| start_det | input | 1 | Pulse when a start bit is detected |
| frame_done | input | 1 | Pulse when a frame is complete |
| frame_data | input | DATA_W | Data bits of the finished frame |
| frame_bit9 | input | 1 | Ninth data bit of the finished frame |
| frame_ferr | input | 1 | Framing fault of the finished frame |
| frame_perr | input | 1 | Parity fault of the finished frame |
| rd_pop | input | 1 | Host pop strobe |
| avail | output | 1 | At least one frame is stored |
| head_data | output | DATA_W | Data of the head frame |
| head_bit9 | output | 1 | Ninth bit of the head frame |
| head_ferr | output | 1 | Framing fault of the head frame |
| head_perr | output | 1 | Parity fault of the head frame |
| head_ovr | output | 1 | An overrun preceded the head frame |

## Verification
The assertions assume that the front end follows the receive protocol. Every `frame_done` comes after its own `start_det`, and the two pulses never fall in the same cycle. This means a frame never completes while a frame is held and both slots are full, because the start pulse of that frame would already have caused an overrun. The random stimulus enforces this order with an in-frame flag. The directed sequences pulse start and done in separate cycles.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
  // Status bits stored beside the data bits of every frame.
  localparam int RXQ_FRAME_FLAGS = 3;
  localparam int RXQ_ENTRY_FLAGS = 4;

  function automatic int unsigned rxq_ptr_next(input int unsigned ptr, input int unsigned depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction

  function automatic logic rxq_overrun(input logic start, input logic held, input logic full);
    return start & held & full;
  endfunction
endpackage

// File: rtl/rxq_ring.sv
`timescale 1ns/1ps
module rxq_ring #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 12,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  import rxq_pkg::*;

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_wr, do_rd;

  assign full  = (count_q == CNT_W'(DEPTH));
  assign empty = (count_q == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (do_wr && (wr_ptr_q == PTR_W'(g)))
        slot_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= PTR_W'(rxq_ptr_next(int'(wr_ptr_q), DEPTH));
      if (do_rd) rd_ptr_q <= PTR_W'(rxq_ptr_next(int'(rd_ptr_q), DEPTH));
      case ({do_wr, do_rd})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rd_data = slot_q[rd_ptr_q];
  assign count   = count_q;
endmodule

// File: rtl/rxq_hold.sv
`timescale 1ns/1ps
module rxq_hold #(
  parameter int FRM_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             start_det,
  input  logic             frame_done,
  input  logic [FRM_W-1:0] frame_vec,
  input  logic             ring_full,
  output logic             hold_valid,
  output logic             move_evt,
  output logic             direct_evt,
  output logic             overrun_evt,
  output logic             ovr_pending,
  output logic             fifo_wr,
  output logic [FRM_W:0]   fifo_wdata
);
  import rxq_pkg::*;

  logic             hv_q, ovr_q;
  logic [FRM_W-1:0] hold_q;

  assign move_evt    = hv_q && !ring_full;
  assign direct_evt  = frame_done && !hv_q && !ring_full;
  assign overrun_evt = rxq_overrun(start_det, hv_q, ring_full);
  assign fifo_wr     = move_evt || direct_evt;
  assign fifo_wdata  = {ovr_q, (move_evt ? hold_q : frame_vec)};

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      hv_q   <= 1'b0;
      hold_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (frame_done && !direct_evt) begin
        hv_q   <= 1'b1;
        hold_q <= frame_vec;
      end else if (move_evt || overrun_evt) begin
        hv_q   <= 1'b0;
      end
      if (overrun_evt)
        ovr_q <= 1'b1;
      else if (fifo_wr)
        ovr_q <= 1'b0;
    end
  end

  assign hold_valid  = hv_q;
  assign ovr_pending = ovr_q;
endmodule

// File: rtl/rx_status_fifo.sv
`timescale 1ns/1ps
module rx_status_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              start_det,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_bit9,
  input  logic              frame_ferr,
  input  logic              frame_perr,
  input  logic              rd_pop,
  output logic              avail,
  output logic [DATA_W-1:0] head_data,
  output logic              head_bit9,
  output logic              head_ferr,
  output logic              head_perr,
  output logic              head_ovr
);
  import rxq_pkg::*;

  localparam int FRM_W = DATA_W + RXQ_FRAME_FLAGS;
  localparam int ENT_W = DATA_W + RXQ_ENTRY_FLAGS;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             flush, start_g, done_g, pop_g;
  logic [FRM_W-1:0] frame_vec;
  logic [ENT_W-1:0] wr_ent, head_ent;
  logic [CNT_W-1:0] count;
  logic             full, empty;
  logic             hold_valid, move_evt, direct_evt, overrun_evt, ovr_pending, fifo_wr;

  assign flush     = !rx_en;
  assign start_g   = start_det && rx_en;
  assign done_g    = frame_done && rx_en;
  assign pop_g     = rd_pop && rx_en;
  assign frame_vec = {frame_perr, frame_ferr, frame_bit9, frame_data};

  rxq_hold #(.FRM_W(FRM_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .start_det(start_g), .frame_done(done_g), .frame_vec(frame_vec),
    .ring_full(full),
    .hold_valid(hold_valid), .move_evt(move_evt), .direct_evt(direct_evt),
    .overrun_evt(overrun_evt), .ovr_pending(ovr_pending),
    .fifo_wr(fifo_wr), .fifo_wdata(wr_ent)
  );

  rxq_ring #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(fifo_wr), .wr_data(wr_ent), .rd_en(pop_g),
    .rd_data(head_ent), .count(count), .full(full), .empty(empty)
  );

  assign avail     = !empty;
  assign head_data = head_ent[DATA_W-1:0];
  assign head_bit9 = head_ent[DATA_W];
  assign head_ferr = head_ent[DATA_W+1];
  assign head_perr = head_ent[DATA_W+2];
  assign head_ovr  = head_ent[DATA_W+3];
endmodule

// File: rtl/rxq_checker.sv
`timescale 1ns/1ps
module rxq_checker #(
  parameter int DEPTH = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             rd_pop,
  input logic             avail,
  input logic             head_ovr,
  input logic [CNT_W-1:0] count,
  input logic             hold_valid,
  input logic             move_evt,
  input logic             overrun_evt,
  input logic             ovr_pending,
  input logic             fifo_wr,
  input logic             done_g
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_held_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (move_evt && !done_g) |=> !hold_valid);

  assert_overrun_pends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> ovr_pending);

  assert_mark_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && ovr_pending) |=> !ovr_pending);

  assert_mark_at_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && ovr_pending && !avail) |=> head_ovr);

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail && rd_pop && !fifo_wr) |=> !avail);

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!avail && !hold_valid && !ovr_pending));
endmodule

bind rx_status_fifo rxq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_pop(rd_pop),
  .avail(avail), .head_ovr(head_ovr), .count(count),
  .hold_valid(hold_valid), .move_evt(move_evt), .overrun_evt(overrun_evt),
  .ovr_pending(ovr_pending), .fifo_wr(fifo_wr), .done_g(done_g)
);

// File: tb/sim_rx_status_fifo.sv
`timescale 1ns/1ps
module sim_rx_status_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b1;
  logic       start_det = 1'b0, frame_done = 1'b0, rd_pop = 1'b0;
  logic [7:0] frame_data = '0;
  logic       frame_bit9 = 1'b0, frame_ferr = 1'b0, frame_perr = 1'b0;
  logic       avail, head_bit9, head_ferr, head_perr, head_ovr;
  logic [7:0] head_data;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  rx_status_fifo #(.DATA_W(8), .DEPTH(2)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .start_det(start_det),
    .frame_done(frame_done), .frame_data(frame_data), .frame_bit9(frame_bit9),
    .frame_ferr(frame_ferr), .frame_perr(frame_perr), .rd_pop(rd_pop),
    .avail(avail), .head_data(head_data), .head_bit9(head_bit9),
    .head_ferr(head_ferr), .head_perr(head_perr), .head_ovr(head_ovr)
  );

  typedef struct { logic [7:0] d; logic b9, fe, pe, ov; } ent_t;
  ent_t q[$];
  ent_t held;
  bit   held_v = 0, ovr_pend = 0;

  function automatic logic [11:0] pack(ent_t e);
    return {e.ov, e.pe, e.fe, e.b9, e.d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: list semantics of the requirements, evaluated on each edge.
  task automatic model_edge();
    ent_t nf, w;
    bit full, wr, take_held, ovr_evt, direct;
    if (!rst_n || !rx_en) begin
      q.delete(); held_v = 0; ovr_pend = 0;
      return;
    end
    nf = '{frame_data, frame_bit9, frame_ferr, frame_perr, 1'b0};
    full = (q.size() >= 2);
    ovr_evt = start_det && held_v && full;
    take_held = held_v && !full;
    direct = frame_done && !held_v && !full;
    wr = take_held || direct;
    w = take_held ? held : nf;
    w.ov = ovr_pend;
    if (rd_pop && q.size() > 0) void'(q.pop_front());
    if (wr) q.push_back(w);
    if (frame_done && !direct) begin held = nf; held_v = 1; end
    else if (take_held || ovr_evt) held_v = 0;
    if (ovr_evt) ovr_pend = 1;
    else if (wr) ovr_pend = 0;
  endtask

  task automatic compare();
    chk(avail == (q.size() > 0), cur_req, {11'd0, avail}, {11'd0, q.size() > 0});
    if (avail && q.size() > 0)
      chk({head_ovr, head_perr, head_ferr, head_bit9, head_data} == pack(q[0]), cur_req,
          {head_ovr, head_perr, head_ferr, head_bit9, head_data}, pack(q[0]));
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    start_det = 0; frame_done = 0; rd_pop = 0;
  endtask

  task automatic do_start(); start_det = 1; tick(); endtask
  task automatic do_pop();   rd_pop = 1; tick(); endtask
  task automatic do_idle();  tick(); endtask
  task automatic do_frame(input logic [7:0] d, input logic b9, input logic fe, input logic pe);
    start_det = 1; tick();
    frame_done = 1; frame_data = d; frame_bit9 = b9; frame_ferr = fe; frame_perr = pe; tick();
  endtask

  task automatic head_is(input string req, input logic [7:0] d, input logic b9,
                         input logic fe, input logic pe, input logic ov);
    chk(avail && {head_ovr, head_perr, head_ferr, head_bit9, head_data} == {ov, pe, fe, b9, d},
        req, {head_ovr, head_perr, head_ferr, head_bit9, head_data}, {ov, pe, fe, b9, d});
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!avail, "R1", {11'd0, avail}, 12'd0);
    rst_n = 1;
    cur_req = "R1"; tick();
    chk(!avail, "R1", {11'd0, avail}, 12'd0);

    cur_req = "R2"; do_frame(8'h5A, 1, 0, 1);
    head_is("R2", 8'h5A, 1, 0, 1, 0);
    cur_req = "R3"; do_frame(8'hC3, 0, 1, 0);
    head_is("R3", 8'h5A, 1, 0, 1, 0);
    cur_req = "R4"; do_pop();
    head_is("R10", 8'hC3, 0, 1, 0, 0);

    cur_req = "R5";
    do_frame(8'h11, 0, 0, 0);
    do_frame(8'h22, 1, 1, 1);
    head_is("R5", 8'hC3, 0, 1, 0, 0);
    do_pop();
    head_is("R4", 8'h11, 0, 0, 0, 0);
    do_idle();
    do_pop();
    head_is("R5", 8'h22, 1, 1, 1, 0);
    do_pop();
    chk(!avail, "R4", {11'd0, avail}, 12'd0);

    cur_req = "R6";
    do_frame(8'h31, 0, 0, 0);
    do_frame(8'h32, 0, 0, 0);
    do_frame(8'h33, 0, 0, 0);
    do_frame(8'h44, 0, 1, 0);
    head_is("R6", 8'h31, 0, 0, 0, 0);
    do_pop();
    head_is("R6", 8'h32, 0, 0, 0, 0);
    do_idle();
    do_pop();
    head_is("R6", 8'h44, 0, 1, 0, 1);
    do_frame(8'h55, 1, 0, 0);
    do_pop();
    head_is("R6", 8'h55, 1, 0, 0, 0);

    cur_req = "R7";
    do_frame(8'h66, 0, 0, 1);
    do_frame(8'h67, 0, 0, 0);
    do_pop();
    head_is("R7", 8'h66, 0, 0, 1, 0);
    do_idle();
    do_pop();
    head_is("R7", 8'h67, 0, 0, 0, 0);
    do_pop();

    cur_req = "R8";
    do_pop();
    chk(!avail, "R8", {11'd0, avail}, 12'd0);
    do_pop();
    do_frame(8'h70, 0, 0, 0);
    head_is("R8", 8'h70, 0, 0, 0, 0);

    cur_req = "R9";
    do_frame(8'h71, 0, 0, 0);
    do_frame(8'h72, 0, 0, 0);
    do_start();
    rx_en = 0;
    do_idle();
    chk(!avail, "R9", {11'd0, avail}, 12'd0);
    do_frame(8'hEE, 1, 1, 1);
    chk(!avail, "R9", {11'd0, avail}, 12'd0);
    rx_en = 1;
    do_frame(8'h77, 0, 0, 0);
    head_is("R9", 8'h77, 0, 0, 0, 0);
    do_pop();

    cur_req = "R10";
    begin
      bit in_frame = 0;
      for (int i = 0; i < 2000; i++) begin
        rx_en = ($urandom_range(0, 79) != 0);
        if (!in_frame && $urandom_range(0, 3) == 0) begin
          start_det = 1; in_frame = 1;
        end else if (in_frame && $urandom_range(0, 2) == 0) begin
          frame_done = 1; in_frame = 0;
          frame_data = 8'($urandom);
          frame_bit9 = 1'($urandom); frame_ferr = 1'($urandom); frame_perr = 1'($urandom);
        end
        rd_pop = ($urandom_range(0, 3) == 0);
        tick();
      end
    end
    rx_en = 1;
    summary();
  end
endmodule